// File: doc/BRIEF.md
# Configuration Region Checksum Engine

The engine computes a 16-bit checksum over a contiguous run of bytes held in a byte-addressable configuration memory. A one-cycle start pulse gives it a start address, a byte count, a write-back enable and a write-back address. It then reads the region through a synchronous read port that has one cycle of latency, and folds the data into a 16-bit checksum register that begins at 0xFFFF. When it finishes it raises a one-cycle done pulse and presents the result.

Each update takes a 16-bit word. The window that forms the word slides by one byte at a time, so consecutive words share a byte. The engine keeps the previous byte in a register, so it reads every memory byte only once. When the count is odd, one last update uses the final byte as the high half of the word. If write-back is enabled, the engine stores the result into the memory itself, most significant byte first, before it signals done. A typical use covers 0xF8 bytes from address 0 and stores the checksum at 0xFC.

Top module: `cfg_crc_engine`

## Requirements
- R1: After reset, busy, done, mem_rd_en and mem_wr_en are low and result is 0x0000.
- R2: A start with byte_count zero reads no memory. It asserts done on the cycle after the start and reports 0xFFFF. If write-back is enabled, it first writes 0xFF to wb_addr and 0xFF to wb_addr+1.
- R3: The checksum register starts at 0xFFFF. Each update with a 16-bit word w turns the previous value c into the new value c', as follows: let d = c XOR w, p1 = d[3:0] and p2 = d[7:4] XOR p1. Then c' = (c >> 8) XOR (p1 << 3) XOR (p1 << 8) XOR p2 XOR (p2 << 7) XOR (p2 << 12), truncated to 16 bits.
- R4: Let E be byte_count with bit 0 cleared. For each offset i from 0 to E-1, one update uses the big-endian word whose high byte is at start_addr+i and whose low byte is at start_addr+i+1.
  - The engine reads each byte once, at ascending consecutive addresses starting at start_addr.
  - It makes E+1 reads when E > 0, one read when the count is 1, and none when the count is 0.
- R5: For an odd byte_count, one final update uses the word {byte at start_addr+E, 8'h00}.
- R6: done is a one-cycle pulse and occurs only while the engine is idle. result changes only in the cycle in which done is high, and holds its value until the next completion.
- R7: A start pulse while busy is high is ignored. It does not change the run in progress, its result, or the number of completions.
- R8: With write-back enabled, the engine writes result[15:8] to wb_addr and then result[7:0] to wb_addr+1, on two consecutive cycles, before done. Reads and writes never occur in the same cycle. With write-back disabled, mem_wr_en stays low.
- R9: For the standard use (start 0, count 0xF8, write-back at 0xFC), the checksum is the value defined by R3 to R5 over those bytes, and it lands big-endian at 0xFC and 0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled only while idle |
| start_addr | input | AW | First byte address of the region |
| byte_count | input | CW | Number of bytes in the region |
| wb_en | input | 1 | Store the result into memory when set |
| wb_addr | input | AW | Address for the high result byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Checksum of the last completed run |

## Verification
The bench builds the engine with AW = 8 and CW = 9. With these values a 256-byte memory model covers the whole address space, and it can run the full 0xF8-byte standard region with write-back at 0xFC. Short runs of 0, 1, 2 and 3 bytes reach the corner cases: no read at all, a tail update with no word update, and a single overlapping word. Odd and even counts at nonzero start addresses check where the sliding window starts and where it ends.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TAIL,
        ST_WB_HI,
        ST_WB_LO
    } eng_state_e;

    // Tag that travels with a read request through the one-cycle read latency
    typedef struct packed {
        logic valid;
        logic last;
    } rd_tag_t;

    // One checksum update with a 16-bit word
    function automatic logic [15:0] crc_step(input logic [15:0] prev,
                                             input logic [15:0] word);
        logic [15:0] d;
        logic [15:0] p1;
        logic [15:0] p2;
        d  = prev ^ word;
        p1 = {12'h000, d[3:0]};
        p2 = {12'h000, d[7:4] ^ d[3:0]};
        return (prev >> 8) ^ (p1 << 3) ^ (p1 << 8) ^ p2 ^ (p2 << 7) ^ (p2 << 12);
    endfunction

endpackage

// File: rtl/cfg_crc_rdseq.sv
module cfg_crc_rdseq
    import cfg_crc_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW:0]   load_n,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output rd_tag_t       tag
);
    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [CW:0]   REM_ONE  = {{CW{1'b0}}, 1'b1};

    logic [AW-1:0] addr_q;
    logic [CW:0]   rem_q;

    assign rd_en   = (rem_q != '0);
    assign rd_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
            tag    <= '0;
        end else begin
            tag.valid <= rd_en;
            tag.last  <= rd_en && (rem_q == REM_ONE);
            if (load) begin
                addr_q <= load_addr;
                rem_q  <= load_n;
            end else if (rd_en) begin
                addr_q <= addr_q + ADDR_ONE;
                rem_q  <= rem_q - REM_ONE;
            end
        end
    end
endmodule

// File: rtl/cfg_crc_accum.sv
module cfg_crc_accum
    import cfg_crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        data_vld,
    input  logic [7:0]  data,
    input  logic        tail,
    output logic [15:0] crc,
    output logic [15:0] crc_nxt
);
    logic [15:0] crc_q;
    logic [7:0]  prev_q;
    logic        have_q;

    always_comb begin
        crc_nxt = crc_q;
        if (tail) begin
            crc_nxt = crc_step(crc_q, {prev_q, 8'h00});
        end else if (data_vld && have_q) begin
            crc_nxt = crc_step(crc_q, {prev_q, data});
        end
    end

    assign crc = crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= CRC_SEED;
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (init) begin
            crc_q  <= CRC_SEED;
            have_q <= 1'b0;
        end else begin
            crc_q <= crc_nxt;
            if (data_vld) begin
                prev_q <= data;
                have_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_crc_engine.sv
module cfg_crc_engine
    import cfg_crc_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_count,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    output logic          busy,
    output logic          done,
    output logic [15:0]   result
);
    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};

    eng_state_e    state_q;
    logic          odd_q;
    logic          wb_q;
    logic [AW-1:0] wba_q;
    logic          done_q;
    logic [15:0]   result_q;

    logic          accept;
    logic [CW-1:0] even_cnt;
    logic [CW:0]   n_reads;
    rd_tag_t       tag;
    logic [15:0]   crc;
    logic [15:0]   crc_nxt;
    logic          finish;
    logic [15:0]   finish_val;
    eng_state_e    state_d;

    assign accept   = start && (state_q == ST_IDLE);
    assign even_cnt = {byte_count[CW-1:1], 1'b0};

    always_comb begin
        if (even_cnt != '0) begin
            n_reads = {1'b0, even_cnt} + {{CW{1'b0}}, 1'b1};
        end else begin
            n_reads = {{CW{1'b0}}, byte_count[0]};
        end
    end

    cfg_crc_rdseq #(.AW(AW), .CW(CW)) u_rdseq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_addr (start_addr),
        .load_n    (n_reads),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .tag       (tag)
    );

    cfg_crc_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .init     (accept),
        .data_vld (tag.valid),
        .data     (mem_rd_data),
        .tail     (state_q == ST_TAIL),
        .crc      (crc),
        .crc_nxt  (crc_nxt)
    );

    // Next state and completion decision
    always_comb begin
        state_d    = state_q;
        finish     = 1'b0;
        finish_val = crc_nxt;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (byte_count != '0) begin
                        state_d = ST_FETCH;
                    end else if (wb_en) begin
                        state_d = ST_WB_HI;
                    end else begin
                        finish     = 1'b1;
                        finish_val = CRC_SEED;
                    end
                end
            end
            ST_FETCH: begin
                if (tag.valid && tag.last) begin
                    if (odd_q) begin
                        state_d = ST_TAIL;
                    end else if (wb_q) begin
                        state_d = ST_WB_HI;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (wb_q) begin
                    state_d = ST_WB_HI;
                end else begin
                    finish = 1'b1;
                end
            end
            ST_WB_HI: state_d = ST_WB_LO;
            ST_WB_LO: finish = 1'b1;
            default:  state_d = ST_IDLE;
        endcase
        if (finish) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            odd_q    <= 1'b0;
            wb_q     <= 1'b0;
            wba_q    <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (finish) begin
                result_q <= finish_val;
            end
            if (accept) begin
                odd_q <= byte_count[0];
                wb_q  <= wb_en;
                wba_q <= wb_addr;
            end
        end
    end

    assign mem_wr_en   = (state_q == ST_WB_HI) || (state_q == ST_WB_LO);
    assign mem_wr_addr = (state_q == ST_WB_LO) ? (wba_q + ADDR_ONE) : wba_q;
    assign mem_wr_data = (state_q == ST_WB_LO) ? crc[7:0] : crc[15:8];

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/cfg_crc_engine_chk.sv
module cfg_crc_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_wr_addr,
    input logic          busy,
    input logic          done,
    input logic [15:0]   result
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    assert_rd_ascending_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ONE));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_port_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    assert_wb_pair_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == $past(mem_wr_addr) + ONE));
endmodule

bind cfg_crc_engine cfg_crc_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .busy        (busy),
    .done        (done),
    .result      (result)
);

// File: tb/cfg_crc_engine_tb.sv
module cfg_crc_engine_tb;
    localparam int AW = 8;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic          wb_en = 1'b0;
    logic [AW-1:0] wb_addr = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [7:0]    mem_wr_data;
    logic          busy;
    logic          done;
    logic [15:0]   result;

    always #10 clk = ~clk;

    cfg_crc_engine #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .wb_en(wb_en), .wb_addr(wb_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .done(done), .result(result)
    );

    // Memory model with one-cycle read latency
    logic [7:0] mem [0:255];
    int rd_cnt;
    int first_rd;
    int wr_cnt;
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr];
            if (first_rd < 0) first_rd = int'(mem_rd_addr);
            rd_cnt = rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_cnt = wr_cnt + 1;
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] crc;
        int          nrd;
        int          first;
        int          nwr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] d, p1, p2;
        d  = c ^ w;
        p1 = {12'h0, d[3:0]};
        p2 = {12'h0, d[7:4] ^ d[3:0]};
        return (c >> 8) ^ (p1 << 3) ^ (p1 << 8) ^ p2 ^ (p2 << 7) ^ (p2 << 12);
    endfunction

    function automatic logic [15:0] model(input int sa, input int cnt);
        logic [15:0] c;
        int e;
        c = 16'hFFFF;
        e = cnt & ~1;
        for (int i = 0; i < e; i++)
            c = step(c, {mem[(sa + i) % 256], mem[(sa + i + 1) % 256]});
        if (cnt % 2 == 1)
            c = step(c, {mem[(sa + e) % 256], 8'h00});
        return c;
    endfunction

    // Monitor: pop and compare at every done
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(result == x.crc, {x.tag, " checksum"}, int'(result), int'(x.crc));
                check(rd_cnt == x.nrd, {x.tag, " R4 read count"}, rd_cnt, x.nrd);
                if (x.nrd > 0)
                    check(first_rd == x.first, {x.tag, " R4 first read address"}, first_rd, x.first);
                check(wr_cnt == x.nwr, {x.tag, " R8 write count"}, wr_cnt, x.nwr);
            end
        end
    end

    task automatic launch(input int sa, input int cnt, input bit wb, input int wba, input string tag);
        exp_t x;
        int e;
        while (busy) @(negedge clk);
        e = cnt & ~1;
        x.crc   = model(sa, cnt);
        x.nrd   = (e > 0) ? e + 1 : cnt;
        x.first = sa;
        x.nwr   = wb ? 2 : 0;
        x.tag   = tag;
        sb.push_back(x);
        rd_cnt = 0; first_rd = -1; wr_cnt = 0;
        start_addr = AW'(sa); byte_count = CW'(cnt); wb_en = wb; wb_addr = AW'(wba);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        summary();
    end

    initial begin
        logic [15:0] held;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        rd_cnt = 0; first_rd = -1; wr_cnt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 control outputs low", {busy, done, mem_rd_en, mem_wr_en}, 0);
        check(result == 16'h0000, "R1 result after reset", int'(result), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 zero count: done on the cycle after start
        launch(10, 0, 0, 0, "R2 zero count");
        check(done == 1'b1, "R2 done one cycle after start", int'(done), 1);
        check(result == 16'hFFFF, "R2 zero result", int'(result), 16'hFFFF);
        @(negedge clk);
        check(done == 1'b0, "R6 done is a single pulse", int'(done), 0);

        // R2 zero count with write-back
        launch(10, 0, 1, 8'hE0, "R2 zero wb");
        finish_run();
        check(mem[8'hE0] == 8'hFF && mem[8'hE1] == 8'hFF, "R2 zero wb bytes", {mem[8'hE0], mem[8'hE1]}, 16'hFFFF);

        // R5 count one: tail only
        launch(5, 1, 0, 0, "R5 count one");
        finish_run();
        // R3 / R4 two and three bytes
        launch(7, 2, 0, 0, "R3 count two");
        finish_run();
        launch(20, 3, 0, 0, "R5 count three");
        finish_run();
        // R4 even and odd counts at other starts
        launch(33, 16, 0, 0, "R4 even sixteen");
        finish_run();
        launch(64, 45, 0, 0, "R5 odd forty-five");
        finish_run();
        launch(100, 100, 0, 0, "R3 hundred bytes");
        finish_run();

        // R6 result holds after done
        held = result;
        repeat (6) @(negedge clk);
        check(result == held, "R6 result holds", int'(result), int'(held));

        // R8 write-back disabled leaves memory untouched
        mem[8'hF0] = 8'hA5; mem[8'hF1] = 8'h5A;
        launch(12, 9, 0, 8'hF0, "R8 no wb");
        finish_run();
        check(mem[8'hF0] == 8'hA5 && mem[8'hF1] == 8'h5A, "R8 no write when disabled", {mem[8'hF0], mem[8'hF1]}, 16'hA55A);

        // R7 start ignored while busy
        launch(40, 60, 0, 0, "R7 run under second start");
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R7 engine busy mid run", int'(busy), 1);
        start_addr = 8'd3; byte_count = 9'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_run();
        repeat (8) @(negedge clk);
        check(busy == 1'b0, "R7 no second run", int'(busy), 0);

        // R9 standard region with write-back at 0xFC
        launch(0, 8'hF8, 1, 8'hFC, "R9 standard");
        held = model(0, 8'hF8);
        finish_run();
        @(negedge clk);
        check(mem[8'hFC] == held[15:8], "R9 high byte at 0xFC", int'(mem[8'hFC]), int'(held[15:8]));
        check(mem[8'hFD] == held[7:0], "R9 low byte at 0xFD", int'(mem[8'hFD]), int'(held[7:0]));
        check(result == held, "R8 result equals stored value", int'(result), int'(held));

        repeat (4) @(negedge clk);
        summary();
    end
endmodule